// File: doc/BRIEF.md
# Multiprocessor Level Interrupt Controller

This block gathers a vector of level-sensitive interrupt lines and presents each of several CPUs with an interrupt request output and an acknowledge value. Each source has one global enable bit. Each source also has one mask bit for every CPU. Software never writes bitmaps. To change a bit, it writes a source number to a set or clear command register, and only that one bit changes.

Every bus access carries a CPU index, and the per-CPU registers act on the CPU named by that index. When a CPU reads its acknowledge register, it gets the lowest-numbered source whose input is high, that is globally enabled and that is unmasked for that CPU. If no source qualifies, it gets the idle code 1023. Source numbers 0 to 7 are kept for inter-processor signals, which the surrounding logic drives onto the same input vector. Ordinary peripheral lines start at number 8. Because the lowest ID wins, inter-processor signals are always served first. A read-only capability register reports how many sources are built in.

Top module: `mpic_core`

## Requirements
- R1: After reset every source is disabled, every per-CPU mask bit is set, every `cpu_irq` bit is low and every CPU's acknowledge read returns 1023.
- R2: Writing N to offset 0x30 enables source N globally. Writing N to offset 0x34 disables it.
- R3: Writing N to offset 0x48 masks source N for the CPU selected by `bus_cpu`. Writing N to offset 0x4C unmasks it. The mask bits of the other CPUs do not change.
- R4: A read of offset 0x44 returns, in bits [9:0], the lowest source ID that is high, enabled and unmasked for the selected CPU. It returns 1023 when no source qualifies. Bits [31:10] are zero.
- R5: A read of offset 0x00 returns the number of sources in bits [11:2]. All other bits are zero.
- R6: Sources are levels. A source stays eligible while its input is high, and repeated acknowledge reads return the same ID. Once the input falls, reads move on to the next eligible ID or to 1023.
- R7: `cpu_irq[c]` is high exactly when an acknowledge read by CPU c would return a value below 1023. It follows the inputs and register state with one clock of latency.
- R8: A command write whose value is NSRC or larger changes nothing. A write to offset 0x00 changes nothing. A read of any other offset returns zero.
- R9: Read data appears on `bus_rdata` one clock after the read is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | CPU index for per-CPU registers |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data (source number for commands) |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | NSRC | Level interrupt inputs, bit i = source ID i |
| cpu_irq | output | NCPU | Registered per-CPU interrupt request |

## Verification
The hardest situation to reach from the ports is a write whose value is out of range but whose low bits alias a real source. The stimulus writes 64+10 to the unmask command for one CPU while source 10 is high and enabled. If the number were truncated, that CPU would see source 10. The per-CPU separation is reached in a similar way: source 10 is left unmasked for CPU 0 only, and the bench reads both CPU 0 and CPU 1 and checks that they return different results. Priority is exercised by raising an inter-processor ID beside a peripheral ID, dropping it, and confirming that the peripheral then wins.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam int DW      = 32;
  localparam int AW      = 8;
  localparam int ID_W    = 10;
  localparam logic [ID_W-1:0] IDLE_ID = 10'd1023;

  localparam logic [AW-1:0] OFS_CAPS    = 8'h00;
  localparam logic [AW-1:0] OFS_EN_SET  = 8'h30;
  localparam logic [AW-1:0] OFS_EN_CLR  = 8'h34;
  localparam logic [AW-1:0] OFS_ACK     = 8'h44;
  localparam logic [AW-1:0] OFS_MSK_SET = 8'h48;
  localparam logic [AW-1:0] OFS_MSK_CLR = 8'h4C;
endpackage

// File: rtl/mpic_enable_bank.sv
module mpic_enable_bank
  import mpic_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_cmd,
  input  logic            clr_cmd,
  input  logic [DW-1:0]   num,
  output logic [NSRC-1:0] en_q
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic            in_range;
  logic [IDX_W-1:0] idx;

  assign in_range = (num < DW'(NSRC));
  assign idx      = num[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (in_range) begin
      if (set_cmd) en_q[idx] <= 1'b1;
      if (clr_cmd) en_q[idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/mpic_mask_bank.sv
module mpic_mask_bank
  import mpic_pkg::*;
#(
  parameter int NSRC  = 64,
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_cmd,
  input  logic                      clr_cmd,
  input  logic [CPU_W-1:0]          cpu,
  input  logic [DW-1:0]             num,
  output logic [NCPU-1:0][NSRC-1:0] mask_q
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic             in_range;
  logic [IDX_W-1:0] idx;

  assign in_range = (num < DW'(NSRC));
  assign idx      = num[IDX_W-1:0];

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic hit;
    assign hit = in_range && (cpu == CPU_W'(c));
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[c] <= '1;
      end else if (hit) begin
        if (set_cmd) mask_q[c][idx] <= 1'b1;
        if (clr_cmd) mask_q[c][idx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mpic_pick.sv
module mpic_pick
  import mpic_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic [NSRC-1:0] elig,
  output logic [ID_W-1:0] id
);
  always_comb begin
    id = IDLE_ID;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) id = ID_W'(i);
    end
  end
endmodule

// File: rtl/mpic_core.sv
module mpic_core
  import mpic_pkg::*;
#(
  parameter int NSRC  = 64,
  parameter int NCPU  = 4,
  parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [CPU_W-1:0] bus_cpu,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NSRC-1:0]  src_in,
  output logic [NCPU-1:0]  cpu_irq
);
  localparam logic [DW-1:0] CAPS_WORD = DW'(NSRC) << 2;

  logic wr, rd;
  logic [NSRC-1:0]            en_q;
  logic [NCPU-1:0][NSRC-1:0]  mask_q;
  logic [NCPU-1:0][ID_W-1:0]  ack_id;
  logic [ID_W-1:0]            sel_id;

  assign wr = bus_valid &&  bus_write;
  assign rd = bus_valid && !bus_write;

  mpic_enable_bank #(.NSRC(NSRC)) u_en (
    .clk     (clk),
    .rst     (rst),
    .set_cmd (wr && bus_addr == OFS_EN_SET),
    .clr_cmd (wr && bus_addr == OFS_EN_CLR),
    .num     (bus_wdata),
    .en_q    (en_q)
  );

  mpic_mask_bank #(.NSRC(NSRC), .NCPU(NCPU), .CPU_W(CPU_W)) u_msk (
    .clk     (clk),
    .rst     (rst),
    .set_cmd (wr && bus_addr == OFS_MSK_SET),
    .clr_cmd (wr && bus_addr == OFS_MSK_CLR),
    .cpu     (bus_cpu),
    .num     (bus_wdata),
    .mask_q  (mask_q)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_pick
    mpic_pick #(.NSRC(NSRC)) u_pick (
      .elig (src_in & en_q & ~mask_q[c]),
      .id   (ack_id[c])
    );
    always_ff @(posedge clk) begin
      if (rst) cpu_irq[c] <= 1'b0;
      else     cpu_irq[c] <= (ack_id[c] != IDLE_ID);
    end
  end

  always_comb begin
    sel_id = IDLE_ID;
    for (int c = 0; c < NCPU; c++) begin
      if (bus_cpu == CPU_W'(c)) sel_id = ack_id[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (bus_addr)
        OFS_CAPS: bus_rdata <= CAPS_WORD;
        OFS_ACK:  bus_rdata <= DW'(sel_id);
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mpic_core_chk.sv
module mpic_core_chk
  import mpic_pkg::*;
#(
  parameter int NSRC  = 64,
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_rdata,
  input logic [NSRC-1:0]  src_in,
  input logic [NCPU-1:0]  cpu_irq
);
  AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cpu_irq == '0); // R1

  AST_NO_IRQ_WITHOUT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $past(src_in) == '0 |-> cpu_irq == '0); // R7

  AST_ACK_FORMAT: assert property (@(posedge clk) disable iff (rst)
    $past(bus_valid && !bus_write && bus_addr == OFS_ACK) |->
      (bus_rdata[DW-1:ID_W] == '0 &&
       (bus_rdata[ID_W-1:0] < ID_W'(NSRC) || bus_rdata[ID_W-1:0] == IDLE_ID))); // R4

  AST_ACK_IDLE_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $past(bus_valid && !bus_write && bus_addr == OFS_ACK && src_in == '0) |->
      bus_rdata[ID_W-1:0] == IDLE_ID); // R6

  AST_CAPS_VALUE: assert property (@(posedge clk) disable iff (rst)
    $past(bus_valid && !bus_write && bus_addr == OFS_CAPS) |->
      bus_rdata == (DW'(NSRC) << 2)); // R5
endmodule

bind mpic_core mpic_core_chk #(.NSRC(NSRC), .NCPU(NCPU), .CPU_W(CPU_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .src_in    (src_in),
  .cpu_irq   (cpu_irq)
);

// File: tb/mpic_core_tb.sv
module mpic_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 64;
  localparam int NCPU = 4;
  localparam int CPU_W = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_valid = 1'b0;
  logic             bus_write = 1'b0;
  logic [CPU_W-1:0] bus_cpu = '0;
  logic [7:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [NSRC-1:0]  src_in = '0;
  logic [NCPU-1:0]  cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit en_m [NSRC];
  bit mask_m [NCPU][NSRC];

  int    q_exp [$];
  string q_tag [$];
  logic  rd_due = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpic_core #(.NSRC(NSRC), .NCPU(NCPU)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_in(src_in), .cpu_irq(cpu_irq)
  );

  function automatic int exp_ack(int c);
    for (int i = 0; i < NSRC; i++)
      if (src_in[i] && en_m[i] && !mask_m[c][i]) return i;
    return 1023;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: R9 read data one clock after request
  always @(posedge clk) rd_due <= bus_valid && !bus_write;
  always @(negedge clk) begin
    if (rd_due && q_exp.size() > 0) begin
      int e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, int'(bus_rdata), e);
    end
  end

  task automatic bus_wr(int c, logic [7:0] a, int d);
    bus_valid = 1; bus_write = 1; bus_cpu = CPU_W'(c); bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(int c, logic [7:0] a, int exp, string tag);
    bus_valid = 1; bus_write = 0; bus_cpu = CPU_W'(c); bus_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic rd_ack(int c, string tag);
    bus_rd(c, 8'h44, exp_ack(c), tag);
  endtask

  task automatic en_set(int n);
    bus_wr(0, 8'h30, n); if (n < NSRC) en_m[n] = 1;
  endtask
  task automatic en_clr(int n);
    bus_wr(0, 8'h34, n); if (n < NSRC) en_m[n] = 0;
  endtask
  task automatic msk_set(int c, int n);
    bus_wr(c, 8'h48, n); if (n < NSRC) mask_m[c][n] = 1;
  endtask
  task automatic msk_clr(int c, int n);
    bus_wr(c, 8'h4C, n); if (n < NSRC) mask_m[c][n] = 0;
  endtask

  task automatic check_irq(string tag);
    repeat (2) @(negedge clk);
    for (int c = 0; c < NCPU; c++)
      check(tag, int'(cpu_irq[c]), (exp_ack(c) != 1023) ? 1 : 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NSRC; i++) begin
      en_m[i] = 0;
      for (int c = 0; c < NCPU; c++) mask_m[c][i] = 1;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    check("R1 irq after reset", int'(cpu_irq), 0);
    for (int c = 0; c < NCPU; c++) rd_ack(c, "R1 reset ack idle");
    bus_rd(0, 8'h00, NSRC << 2, "R5 capability word");
    bus_rd(0, 8'h10, 0, "R8 unmapped read zero");

    en_set(10);
    src_in[10] = 1;
    rd_ack(0, "R3 masked at reset");
    msk_clr(0, 10);
    rd_ack(0, "R2 enabled unmasked source");
    rd_ack(1, "R3 other cpu still masked");
    check_irq("R7 irq follows ack");

    msk_clr(1, NSRC + 10);
    rd_ack(1, "R8 out-of-range number ignored");
    en_set(NSRC + 3);
    src_in[3] = 1;
    msk_clr(0, 3);
    rd_ack(0, "R8 out-of-range enable ignored");

    en_set(3);
    rd_ack(0, "R4 lowest id wins");
    rd_ack(0, "R6 repeat read same id");
    src_in[3] = 0;
    rd_ack(0, "R6 level drop moves on");

    msk_set(0, 10);
    rd_ack(0, "R3 set-mask hides source");
    msk_clr(0, 10);
    en_clr(10);
    rd_ack(0, "R2 clear-enable hides source");
    check_irq("R7 irq drops");

    bus_wr(0, 8'h00, 32'h0000_0FFC);
    bus_rd(0, 8'h00, NSRC << 2, "R8 capability write ignored");

    en_set(NSRC - 1);
    src_in[NSRC-1] = 1;
    msk_clr(2, NSRC - 1);
    rd_ack(2, "R4 top source id");
    rd_ack(3, "R3 cpu3 masked");
    check_irq("R7 irq top source");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule